// File: doc/BRIEF.md
# Transceiver Power Mode Controller

This block decides which parts of a 10/100 Ethernet transceiver are powered or driven. Three configuration bits sit in a small management register file: a whole-chip power-down, a receive idle-gating mode, and a transmit high-impedance mode. The block combines them with the line speed and the receive signal-detect flag. From that it produces registered enables for the receive datapath, the receive clock, the transmit line drivers and the transmit clock output. It also produces an enable for a weak pull-up on the transmit clock pin.

In receive idle-gating mode, the receive circuits are powered only while a valid line signal is detected. They come back as soon as signal detect rises. The mode is ignored at 10 Mb/s. Whole-chip power-down overrides everything else but leaves the management port working. The transmit high-impedance bit is sticky: a management write can set it, and only reset clears it.

Top module: `xcvr_pwr_ctl`

## Requirements
- R1: After reset, all configuration bits are 0. The enables are then rx_path_en=1, rx_clk_en=1, tx_drv_en=1, tx_clk_oe=1 and tx_clk_pu_en=0.
- R2: Writing 1 to bit 11 of address 0 (power-down) drives all five enable outputs to 0.
- R3: Management writes and reads keep working while power-down is set.
- R4: With bit 0 of address 16 set (receive idle-gating) and speed_100=1, rx_path_en and rx_clk_en equal sig_det.
- R5: With speed_100=0, receive idle-gating has no effect: rx_path_en=rx_clk_en=1 whenever power-down is 0.
- R6: Bit 12 of address 16 (transmit high-impedance) drives tx_drv_en=0 and tx_clk_oe=0, and tx_clk_pu_en=1. The receive enables are left unchanged.
- R7: Writing 0 to bit 12 of address 16 does not clear it, and power-down does not clear it. Only reset returns it to 0.
- R8: Power-down overrides both other modes. Clearing it restores the enables that the remaining bits and inputs select.
- R9: Address 0 reads back bit 11 only. Address 16 reads back bits 12 and 0 only. All other bits, and every other address, read 0, and writes to other addresses change nothing.
- R10: Every enable output is registered. It changes on the first clock edge after the edge that stores a write, and on the first edge after a sig_det or speed_100 change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Management clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mgmt_wr | input | 1 | Write strobe, stored on the rising edge |
| mgmt_addr | input | 5 | Register address |
| mgmt_wdata | input | 16 | Write data |
| mgmt_rdata | output | 16 | Read data for mgmt_addr (combinational) |
| speed_100 | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| sig_det | input | 1 | Valid line signal detected |
| rx_path_en | output | 1 | Receive datapath power enable |
| rx_clk_en | output | 1 | Receive clock gate enable |
| tx_drv_en | output | 1 | Transmit line driver enable |
| tx_clk_oe | output | 1 | Transmit clock output enable |
| tx_clk_pu_en | output | 1 | Transmit clock weak pull-up enable |

## Verification
Read data follows the stored bits with no delay, so a write is visible at the negative edge right after the edge that stored it. The enables lag one further edge behind. A sig_det or speed_100 change driven at a negative edge appears in the enables after the next rising edge. The bench drives all inputs at negative edges and samples readback and enables at negative edges that follow these counts. In one directed test it also samples the enables between the two edges, to confirm they still hold their old values there.

// File: rtl/xpc_pkg.sv
package xpc_pkg;
  localparam int ADDR_CTRL   = 0;
  localparam int ADDR_MODE   = 16;
  localparam int BIT_PDN     = 11;
  localparam int BIT_RXGATE  = 0;
  localparam int BIT_TXHIZ   = 12;

  // Receive side powered: no power-down and either gating off, 10 Mb/s, or signal present.
  function automatic logic f_rx_on(input logic pdn, input logic rxgate,
                                   input logic spd100, input logic sd);
    return !pdn && (!rxgate || !spd100 || sd);
  endfunction

  // Transmit drivers and clock driven.
  function automatic logic f_tx_on(input logic pdn, input logic hiz);
    return !pdn && !hiz;
  endfunction

  // Weak pull-up on the transmit clock pin while it floats.
  function automatic logic f_pu_on(input logic pdn, input logic hiz);
    return !pdn && hiz;
  endfunction
endpackage

// File: rtl/xpc_mgmt_regs.sv
module xpc_mgmt_regs
  import xpc_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              pdn_q,
  output logic              rxgate_q,
  output logic              hiz_q
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADDR_CTRL);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(ADDR_MODE);

  logic wr_ctrl, wr_mode;
  assign wr_ctrl = wr && (addr == A_CTRL);
  assign wr_mode = wr && (addr == A_MODE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pdn_q    <= 1'b0;
      rxgate_q <= 1'b0;
      hiz_q    <= 1'b0;
    end else begin
      if (wr_ctrl) pdn_q <= wdata[BIT_PDN];
      if (wr_mode) begin
        rxgate_q <= wdata[BIT_RXGATE];
        hiz_q    <= hiz_q | wdata[BIT_TXHIZ];  // sticky: only reset clears
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == A_CTRL) begin
      rdata[BIT_PDN] = pdn_q;
    end else if (addr == A_MODE) begin
      rdata[BIT_RXGATE] = rxgate_q;
      rdata[BIT_TXHIZ]  = hiz_q;
    end
  end

  // R7: once set, the high-impedance bit stays set until reset
  p_hiz_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hiz_q |=> hiz_q);
endmodule

// File: rtl/xpc_enable_ctrl.sv
module xpc_enable_ctrl
  import xpc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pdn,
  input  logic rxgate,
  input  logic hiz,
  input  logic speed_100,
  input  logic sig_det,
  output logic rx_path_en,
  output logic rx_clk_en,
  output logic tx_drv_en,
  output logic tx_clk_oe,
  output logic tx_clk_pu_en
);
  logic rx_on_nxt, tx_on_nxt, pu_on_nxt;
  assign rx_on_nxt = f_rx_on(pdn, rxgate, speed_100, sig_det);
  assign tx_on_nxt = f_tx_on(pdn, hiz);
  assign pu_on_nxt = f_pu_on(pdn, hiz);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_path_en   <= 1'b1;
      rx_clk_en    <= 1'b1;
      tx_drv_en    <= 1'b1;
      tx_clk_oe    <= 1'b1;
      tx_clk_pu_en <= 1'b0;
    end else begin
      rx_path_en   <= rx_on_nxt;
      rx_clk_en    <= rx_on_nxt;
      tx_drv_en    <= tx_on_nxt;
      tx_clk_oe    <= tx_on_nxt;
      tx_clk_pu_en <= pu_on_nxt;
    end
  end

  // R2: power-down silences every enable one edge later
  p_pdn_all_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pdn |=> !(rx_path_en || rx_clk_en || tx_drv_en || tx_clk_oe || tx_clk_pu_en));

  // R5: at 10 Mb/s the receive side stays powered unless power-down
  p_slow_rx_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!pdn && !speed_100) |=> (rx_path_en && rx_clk_en));

  // R4: gated receive at 100 Mb/s follows signal detect
  p_rx_follow_sd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pdn && rxgate && speed_100) |=> (rx_clk_en == $past(sig_det)));

  // R6: the clock pin is never driven and pulled up at once
  p_txclk_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_clk_oe && tx_clk_pu_en));
endmodule

// File: rtl/xcvr_pwr_ctl.sv
module xcvr_pwr_ctl #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mgmt_wr,
  input  logic [ADDR_W-1:0] mgmt_addr,
  input  logic [DATA_W-1:0] mgmt_wdata,
  output logic [DATA_W-1:0] mgmt_rdata,
  input  logic              speed_100,
  input  logic              sig_det,
  output logic              rx_path_en,
  output logic              rx_clk_en,
  output logic              tx_drv_en,
  output logic              tx_clk_oe,
  output logic              tx_clk_pu_en
);
  logic pdn_w, rxgate_w, hiz_w;

  xpc_mgmt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (mgmt_wr),
    .addr     (mgmt_addr),
    .wdata    (mgmt_wdata),
    .rdata    (mgmt_rdata),
    .pdn_q    (pdn_w),
    .rxgate_q (rxgate_w),
    .hiz_q    (hiz_w)
  );

  xpc_enable_ctrl u_en (
    .clk          (clk),
    .rst_n        (rst_n),
    .pdn          (pdn_w),
    .rxgate       (rxgate_w),
    .hiz          (hiz_w),
    .speed_100    (speed_100),
    .sig_det      (sig_det),
    .rx_path_en   (rx_path_en),
    .rx_clk_en    (rx_clk_en),
    .tx_drv_en    (tx_drv_en),
    .tx_clk_oe    (tx_clk_oe),
    .tx_clk_pu_en (tx_clk_pu_en)
  );
endmodule

// File: tb/xcvr_pwr_ctl_test.sv
`timescale 1ns/1ps
module xcvr_pwr_ctl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mgmt_wr = 1'b0;
  logic [4:0]  mgmt_addr = '0;
  logic [15:0] mgmt_wdata = '0;
  logic [15:0] mgmt_rdata;
  logic        speed_100 = 1'b1;
  logic        sig_det = 1'b0;
  logic        rx_path_en, rx_clk_en, tx_drv_en, tx_clk_oe, tx_clk_pu_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  xcvr_pwr_ctl uut (
    .clk(clk), .rst_n(rst_n), .mgmt_wr(mgmt_wr), .mgmt_addr(mgmt_addr),
    .mgmt_wdata(mgmt_wdata), .mgmt_rdata(mgmt_rdata), .speed_100(speed_100),
    .sig_det(sig_det), .rx_path_en(rx_path_en), .rx_clk_en(rx_clk_en),
    .tx_drv_en(tx_drv_en), .tx_clk_oe(tx_clk_oe), .tx_clk_pu_en(tx_clk_pu_en)
  );

  // {pdn, rxgate, speed_100, sig_det, rx_path, rx_clk, tx_drv, tx_oe, pu}
  localparam logic [8:0] VEC [8] = '{
    9'b0_0_1_0_11110,
    9'b0_1_1_0_00110,
    9'b0_1_1_1_11110,
    9'b0_1_0_0_11110,
    9'b0_0_0_0_11110,
    9'b1_0_1_1_00000,
    9'b1_1_0_0_00000,
    9'b0_1_1_0_00110
  };

  function automatic logic [4:0] outs();
    return {rx_path_en, rx_clk_en, tx_drv_en, tx_clk_oe, tx_clk_pu_en};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    mgmt_wr = 1'b1; mgmt_addr = a; mgmt_wdata = d;
    @(negedge clk);
    mgmt_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    mgmt_addr = a;
    #0.5 d = mgmt_rdata;
  endtask

  task automatic settle();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    do_reset();
    // R1 reset state
    check("R1 outputs", {11'b0, outs()}, 16'h001E);
    rd_reg(5'd0, rd);  check("R1 ctrl", rd, 16'h0000);
    rd_reg(5'd16, rd); check("R1 mode", rd, 16'h0000);

    // table walk
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      speed_100 = VEC[i][6]; sig_det = VEC[i][5];
      wr_reg(5'd0, {4'b0, VEC[i][8], 11'b0});
      wr_reg(5'd16, {15'b0, VEC[i][7]});
      settle();
      if (VEC[i][8])            check("R2/R8 vector", {11'b0, outs()}, {11'b0, VEC[i][4:0]});
      else if (!VEC[i][6])      check("R5 vector",    {11'b0, outs()}, {11'b0, VEC[i][4:0]});
      else                      check("R4 vector",    {11'b0, outs()}, {11'b0, VEC[i][4:0]});
    end

    // R4: sig_det rising restores receive at 100 Mb/s with gating on
    @(negedge clk); sig_det = 1'b1;
    settle(); check("R4 sd rise", {15'b0, rx_clk_en}, 16'h1);

    // R10: timing of a power-down write
    wr_reg(5'd0, 16'h0800);
    check("R10 before", {11'b0, outs()}, 16'h001E);
    settle(); check("R10 after", {11'b0, outs()}, 16'h0000);

    // R3: access during power-down
    wr_reg(5'd16, 16'h0000);
    rd_reg(5'd16, rd); check("R3 write 0", rd, 16'h0000);
    wr_reg(5'd16, 16'h0001);
    rd_reg(5'd16, rd); check("R3 write 1", rd, 16'h0001);
    rd_reg(5'd0, rd);  check("R3 ctrl", rd, 16'h0800);

    // R8: release power-down, gating on, sig_det=1 -> all up
    wr_reg(5'd0, 16'h0000); settle();
    check("R8 restore", {11'b0, outs()}, 16'h001E);

    // R6: transmit high-impedance
    wr_reg(5'd16, 16'h1001); settle();
    check("R6 hiz", {11'b0, outs()}, 16'h0019);

    // R7: write 0 does not clear, power-down does not clear
    wr_reg(5'd16, 16'h0000); settle();
    rd_reg(5'd16, rd); check("R7 write0", rd, 16'h1000);
    check("R7 outs", {11'b0, outs()}, 16'h0019);
    wr_reg(5'd0, 16'h0800); wr_reg(5'd0, 16'h0000); settle();
    rd_reg(5'd16, rd); check("R7 after pdn", rd, 16'h1000);

    // R9: masks and unused addresses
    wr_reg(5'd5, 16'hFFFF);
    rd_reg(5'd5, rd);  check("R9 other addr", rd, 16'h0000);
    rd_reg(5'd0, rd);  check("R9 ctrl untouched", rd, 16'h0000);
    wr_reg(5'd0, 16'hFFFF);
    rd_reg(5'd0, rd);  check("R9 ctrl mask", rd, 16'h0800);
    wr_reg(5'd0, 16'h0000);
    wr_reg(5'd16, 16'hFFFF);
    rd_reg(5'd16, rd); check("R9 mode mask", rd, 16'h1001);

    // R7: reset clears it
    do_reset();
    rd_reg(5'd16, rd); check("R7 reset", rd, 16'h0000);
    check("R1 after reset", {11'b0, outs()}, 16'h001E);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule